// File: doc/BRIEF.md
# Single-Buffer Card Data Mover

This block sits inside a memory-card host controller. It moves one contiguous buffer between system memory and the host's card data FIFO, so software does not have to copy every word through registers. Software programs a mode word (direction, beat width, address stepping), a 64-bit start address split over two 32-bit words, and a self-clearing start bit. The byte count comes from the card data path as a block count times a block size.

In the memory-to-card direction the engine issues one read per beat and hands each returned word to the FIFO push side. In the card-to-memory direction it pops one word per beat from the FIFO and issues a memory write with it. Exactly one beat is in flight at a time. A one-cycle completion pulse goes to the data-end logic after the final beat has been accepted. Two per-channel release bits hold a channel in reset while they read 0. Clearing the active channel's bit abandons a running transfer without a completion pulse.

Top module: `blkdma_engine`

## Requirements
- R1: Register offsets are decoded on a 12-bit byte address. The mode word is at 0x410: bit 0 = address increment (1) or fixed (0), bits [5:4] = width code, bits [17:16] = direction field, of which bit 16 selects the direction (0 = memory to card, 1 = card to memory). The mode word reads back with all other bits 0. The start address low word is at 0x440 and the high word is at 0x444, and both read back as written. Any other offset reads 0.
- R2: Writing 1 to bit 0 of offset 0x414 while idle starts a transfer at that clock edge. In that register, bit 0 always reads 0 and bit 1 reads busy. After reset, busy and done are 0 and no memory request is raised.
- R3: With direction 0, each beat is one memory read (memWe = 0). Each response word is offered on the FIFO push port, and beats follow address order.
- R4: With direction 1, each beat pops one FIFO word and writes it to memory with memWe = 1, in pop order.
- R5: Width code w gives a beat of 2^w bytes. The beat count is blkCount*blkSize >> w, memSize equals w, and data bytes at and above lane 2^w are driven 0.
- R6: In increment mode the address rises by 2^w after each beat. In fixed mode every beat uses the same address.
- R7: The low w bits of the programmed start address are ignored, so every beat address is aligned to the beat size.
- R8: done is high for one cycle, in the cycle after the edge that accepts the final beat (final memGnt of a write, or final push handshake). busy falls at that same edge.
- R9: A start whose beat count is 0 raises done in the cycle after the start edge and issues no memory request.
- R10: Offset 0x418 bit 8 releases the direction-0 channel and bit 9 releases the direction-1 channel, and both reset to 1. While the active channel's bit is 0, a running transfer is dropped at the next edge with busy cleared and no done. A start aimed at a channel held in reset is ignored.
- R11: A start written while busy is ignored. The running transfer keeps its beat count and produces one done.
- R12: A raised memory request holds its address and write data until memGnt. fifoPop is raised only while fifoPopValid is high. No handshake output is active while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 12 | Register byte offset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| blkCount | input | 16 | Number of blocks in the transfer |
| blkSize | input | 12 | Bytes per block |
| memReq | output | 1 | Memory request valid |
| memWe | output | 1 | Memory request is a write |
| memAddr | output | 64 | Memory byte address |
| memSize | output | 2 | Beat width code |
| memWrData | output | 64 | Memory write data |
| memGnt | input | 1 | Memory accepts the request |
| memRspValid | input | 1 | Read response valid |
| memRspData | input | 64 | Read response data |
| fifoPopValid | input | 1 | Card FIFO has a word |
| fifoPopData | input | 64 | Card FIFO head word |
| fifoPop | output | 1 | Take the FIFO head word |
| fifoPushValid | output | 1 | Word offered to card FIFO |
| fifoPushData | output | 64 | Word for card FIFO |
| fifoPushReady | input | 1 | Card FIFO accepts the word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench goes after start addresses that are not aligned to the beat width. An engine that forgot to align them would emit odd addresses and misplace every beat. Fixed-address mode and narrow beats are run next to wide incrementing ones, which exposes a stepper that always adds eight or a data path that leaks stale upper bytes. A zero-length start, a second start during a stalled transfer and a channel reset during a stalled push are each tried. Getting them wrong would show as a hung busy, a doubled beat count, or a completion pulse after an abort. The cycle of the done pulse is measured against the final accepting handshake, so a pulse one cycle late or early is caught.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;

  localparam int REG_AW = 12;

  localparam logic [REG_AW-1:0] OFS_MODE  = 12'h410;
  localparam logic [REG_AW-1:0] OFS_CTRL  = 12'h414;
  localparam logic [REG_AW-1:0] OFS_CHRST = 12'h418;
  localparam logic [REG_AW-1:0] OFS_ADRLO = 12'h440;
  localparam logic [REG_AW-1:0] OFS_ADRHI = 12'h444;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POP,
    ST_REQ,
    ST_WAIT,
    ST_PUSH
  } xferState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;     // snapshot address, width, step and beat count
    logic capMem;   // capture a memory read response
    logic capFifo;  // capture a popped FIFO word
    logic advance;  // one beat accepted: step address, count down
  } dpStrobe_t;

endpackage

// File: rtl/blkdma_ctrl.sv
module blkdma_ctrl
  import blkdma_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              memGnt,
  input  logic              memRspValid,
  input  logic              fifoPopValid,
  input  logic              fifoPushReady,
  input  logic              lastBeat,
  input  logic              zeroLen,
  output dpStrobe_t         strobe,
  output logic [1:0]        modeWidth,
  output logic              modeInc,
  output logic [ADDR_W-1:0] baseAddr,
  output logic              memReq,
  output logic              memWe,
  output logic              fifoPop,
  output logic              fifoPushValid,
  output logic              busy,
  output logic              done
);

  localparam int HI_W = ADDR_W - 32;

  logic [1:0] modeDir;
  logic [1:0] chRst;
  logic       xferDir;
  xferState_t state, stateNxt;
  logic       finish;
  logic       abort;

  logic wrMode, wrCtrl, wrChRst, wrAdrLo, wrAdrHi, startReq;

  assign wrMode   = regWrEn && (regAddr == OFS_MODE);
  assign wrCtrl   = regWrEn && (regAddr == OFS_CTRL);
  assign wrChRst  = regWrEn && (regAddr == OFS_CHRST);
  assign wrAdrLo  = regWrEn && (regAddr == OFS_ADRLO);
  assign wrAdrHi  = regWrEn && (regAddr == OFS_ADRHI);
  assign startReq = wrCtrl && regWrData[0];

  // programmed registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeDir   <= 2'b00;
      modeWidth <= 2'b00;
      modeInc   <= 1'b0;
      chRst     <= 2'b11;
      baseAddr  <= '0;
    end else begin
      if (wrMode) begin
        modeDir   <= regWrData[17:16];
        modeWidth <= regWrData[5:4];
        modeInc   <= regWrData[0];
      end
      if (wrChRst) chRst <= regWrData[9:8];
      if (wrAdrLo) baseAddr[31:0] <= regWrData;
      if (wrAdrHi) baseAddr[ADDR_W-1:32] <= regWrData[HI_W-1:0];
    end
  end

  // read mux
  always_comb begin
    regRdData = '0;
    case (regAddr)
      OFS_MODE:  regRdData = {14'b0, modeDir, 10'b0, modeWidth, 3'b0, modeInc};
      OFS_CTRL:  regRdData = {30'b0, busy, 1'b0};
      OFS_CHRST: regRdData = {22'b0, chRst, 8'b0};
      OFS_ADRLO: regRdData = baseAddr[31:0];
      OFS_ADRHI: regRdData = 32'(baseAddr[ADDR_W-1:32]);
      default:   regRdData = '0;
    endcase
  end

  assign busy  = (state != ST_IDLE);
  assign memWe = xferDir;
  assign abort = busy && !chRst[xferDir];

  // beat sequencer
  always_comb begin
    stateNxt      = state;
    strobe        = '0;
    finish        = 1'b0;
    memReq        = 1'b0;
    fifoPop       = 1'b0;
    fifoPushValid = 1'b0;
    case (state)
      ST_IDLE: begin
        if (startReq && chRst[modeDir[0]]) begin
          strobe.load = 1'b1;
          if (zeroLen) finish = 1'b1;
          else stateNxt = modeDir[0] ? ST_POP : ST_REQ;
        end
      end
      ST_POP: begin
        fifoPop = fifoPopValid;
        if (fifoPopValid) begin
          strobe.capFifo = 1'b1;
          stateNxt = ST_REQ;
        end
      end
      ST_REQ: begin
        memReq = 1'b1;
        if (memGnt) begin
          if (xferDir) begin
            strobe.advance = 1'b1;
            if (lastBeat) finish = 1'b1;
            else stateNxt = ST_POP;
          end else begin
            stateNxt = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (memRspValid) begin
          strobe.capMem = 1'b1;
          stateNxt = ST_PUSH;
        end
      end
      ST_PUSH: begin
        fifoPushValid = 1'b1;
        if (fifoPushReady) begin
          strobe.advance = 1'b1;
          if (lastBeat) finish = 1'b1;
          else stateNxt = ST_REQ;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
    if (finish) stateNxt = ST_IDLE;
    if (abort) begin
      stateNxt      = ST_IDLE;
      strobe        = '0;
      finish        = 1'b0;
      memReq        = 1'b0;
      fifoPop       = 1'b0;
      fifoPushValid = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      xferDir <= 1'b0;
      done    <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= finish;
      if (strobe.load) xferDir <= modeDir[0];
    end
  end

endmodule

// File: rtl/blkdma_datapath.sv
module blkdma_datapath
  import blkdma_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int DATA_W     = 64,
  parameter int BLK_CNT_W  = 16,
  parameter int BLK_SIZE_W = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strobe,
  input  logic [1:0]            modeWidth,
  input  logic                  modeInc,
  input  logic [ADDR_W-1:0]     baseAddr,
  input  logic [BLK_CNT_W-1:0]  blkCount,
  input  logic [BLK_SIZE_W-1:0] blkSize,
  input  logic [DATA_W-1:0]     memRspData,
  input  logic [DATA_W-1:0]     fifoPopData,
  output logic [ADDR_W-1:0]     curAddr,
  output logic [1:0]            curWidth,
  output logic [DATA_W-1:0]     dataOut,
  output logic                  lastBeat,
  output logic                  zeroLen
);

  localparam int LEN_W = BLK_CNT_W + BLK_SIZE_W;
  localparam int LANES = DATA_W / 8;

  logic [LEN_W-1:0]  lenBytes;
  logic [LEN_W-1:0]  beatTotal;
  logic [LEN_W-1:0]  beatsLeft;
  logic [ADDR_W-1:0] lowMask;
  logic [ADDR_W-1:0] alignedBase;
  logic [3:0]        stepNew;
  logic [3:0]        stepReg;
  logic [DATA_W-1:0] dataHold;
  logic [LANES-1:0]  laneOn;

  assign lenBytes    = LEN_W'(blkCount) * LEN_W'(blkSize);
  assign beatTotal   = lenBytes >> modeWidth;
  assign zeroLen     = (beatTotal == '0);
  assign lowMask     = ADDR_W'((8'd1 << modeWidth) - 8'd1);
  assign alignedBase = baseAddr & ~lowMask;
  assign stepNew     = modeInc ? 4'(4'd1 << modeWidth) : 4'd0;
  assign lastBeat    = (beatsLeft == LEN_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr   <= '0;
      curWidth  <= 2'b00;
      stepReg   <= 4'd0;
      beatsLeft <= '0;
    end else if (strobe.load) begin
      curAddr   <= alignedBase;
      curWidth  <= modeWidth;
      stepReg   <= stepNew;
      beatsLeft <= beatTotal;
    end else if (strobe.advance) begin
      curAddr   <= curAddr + ADDR_W'(stepReg);
      beatsLeft <= beatsLeft - LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dataHold <= '0;
    else if (strobe.capMem) dataHold <= memRspData;
    else if (strobe.capFifo) dataHold <= fifoPopData;
  end

  // byte lanes beyond the beat width are driven to zero
  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneOn[g] = (32'(g) < (32'd1 << curWidth));
    assign dataOut[8*g +: 8] = laneOn[g] ? dataHold[8*g +: 8] : 8'h00;
  end

endmodule

// File: rtl/blkdma_engine.sv
module blkdma_engine
  import blkdma_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int DATA_W     = 64,
  parameter int BLK_CNT_W  = 16,
  parameter int BLK_SIZE_W = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_AW-1:0]     regAddr,
  input  logic                  regWrEn,
  input  logic [31:0]           regWrData,
  output logic [31:0]           regRdData,
  input  logic [BLK_CNT_W-1:0]  blkCount,
  input  logic [BLK_SIZE_W-1:0] blkSize,
  output logic                  memReq,
  output logic                  memWe,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [1:0]            memSize,
  output logic [DATA_W-1:0]     memWrData,
  input  logic                  memGnt,
  input  logic                  memRspValid,
  input  logic [DATA_W-1:0]     memRspData,
  input  logic                  fifoPopValid,
  input  logic [DATA_W-1:0]     fifoPopData,
  output logic                  fifoPop,
  output logic                  fifoPushValid,
  output logic [DATA_W-1:0]     fifoPushData,
  input  logic                  fifoPushReady,
  output logic                  busy,
  output logic                  done
);

  dpStrobe_t         strobe;
  logic [1:0]        modeWidth;
  logic              modeInc;
  logic [ADDR_W-1:0] baseAddr;
  logic              lastBeat;
  logic              zeroLen;
  logic [DATA_W-1:0] dataOut;

  blkdma_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .regAddr      (regAddr),
    .regWrEn      (regWrEn),
    .regWrData    (regWrData),
    .regRdData    (regRdData),
    .memGnt       (memGnt),
    .memRspValid  (memRspValid),
    .fifoPopValid (fifoPopValid),
    .fifoPushReady(fifoPushReady),
    .lastBeat     (lastBeat),
    .zeroLen      (zeroLen),
    .strobe       (strobe),
    .modeWidth    (modeWidth),
    .modeInc      (modeInc),
    .baseAddr     (baseAddr),
    .memReq       (memReq),
    .memWe        (memWe),
    .fifoPop      (fifoPop),
    .fifoPushValid(fifoPushValid),
    .busy         (busy),
    .done         (done)
  );

  blkdma_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .BLK_CNT_W (BLK_CNT_W),
    .BLK_SIZE_W(BLK_SIZE_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .modeWidth  (modeWidth),
    .modeInc    (modeInc),
    .baseAddr   (baseAddr),
    .blkCount   (blkCount),
    .blkSize    (blkSize),
    .memRspData (memRspData),
    .fifoPopData(fifoPopData),
    .curAddr    (memAddr),
    .curWidth   (memSize),
    .dataOut    (dataOut),
    .lastBeat   (lastBeat),
    .zeroLen    (zeroLen)
  );

  assign memWrData    = dataOut;
  assign fifoPushData = dataOut;

endmodule

// File: rtl/blkdma_chk.sv
module blkdma_chk #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memGnt,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [1:0]        memSize,
  input logic [DATA_W-1:0] memWrData,
  input logic              fifoPop,
  input logic              fifoPopValid,
  input logic              fifoPushValid,
  input logic              busy,
  input logic              done
);

  logic [ADDR_W-1:0] alignBits;
  logic [DATA_W-1:0] deadLanes;
  assign alignBits = ADDR_W'((8'd1 << memSize) - 8'd1);
  assign deadLanes = (memSize == 2'd3) ? '0 : ~((DATA_W'(1) << (8 << memSize)) - DATA_W'(1));

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGnt |=> (memReq && $stable(memAddr) && $stable(memWrData)) || !busy);

  // R12
  pop_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> fifoPopValid);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq && !fifoPop && !fifoPushValid);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R7
  addr_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr & alignBits) == '0);

  // R5
  lane_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> (memWrData & deadLanes) == '0);

endmodule

bind blkdma_engine blkdma_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .memReq       (memReq),
  .memGnt       (memGnt),
  .memWe        (memWe),
  .memAddr      (memAddr),
  .memSize      (memSize),
  .memWrData    (memWrData),
  .fifoPop      (fifoPop),
  .fifoPopValid (fifoPopValid),
  .fifoPushValid(fifoPushValid),
  .busy         (busy),
  .done         (done)
);

// File: tb/blkdma_engine_bench.sv
module blkdma_engine_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        dir;
    logic [1:0]  wid;
    logic        inc;
    logic [15:0] cnt;
    logic [11:0] sz;
    logic [63:0] addr;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 2'd3, 1'b1, 16'd2, 12'd16, 64'h0000_0000_0000_1000},
    '{1'b1, 2'd3, 1'b1, 16'd1, 12'd24, 64'h0000_0020_0000_0040},
    '{1'b0, 2'd2, 1'b0, 16'd1, 12'd16, 64'h0000_0000_0000_0300},
    '{1'b1, 2'd0, 1'b1, 16'd1, 12'd5,  64'h0000_0000_0000_0401},
    '{1'b1, 2'd1, 1'b0, 16'd2, 12'd4,  64'h0000_0000_0000_0503},
    '{1'b0, 2'd3, 1'b1, 16'd1, 12'd16, 64'h0000_0000_0000_0607}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [15:0] blkCount = '0;
  logic [11:0] blkSize = '0;
  logic        memReq, memWe, memGnt;
  logic [63:0] memAddr, memWrData;
  logic [1:0]  memSize;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic        fifoPopValid = 1'b1;
  logic [63:0] fifoPopData;
  logic        fifoPop, fifoPushValid;
  logic [63:0] fifoPushData;
  logic        fifoPushReady = 1'b1;
  logic        busy, done;
  logic        gntOn = 1'b1;

  int nChk = 0;
  int nFail = 0;

  blkdma_engine u_blkdma_engine (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .blkCount(blkCount),
    .blkSize(blkSize), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memSize(memSize), .memWrData(memWrData), .memGnt(memGnt),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .fifoPopValid(fifoPopValid), .fifoPopData(fifoPopData), .fifoPop(fifoPop),
    .fifoPushValid(fifoPushValid), .fifoPushData(fifoPushData),
    .fifoPushReady(fifoPushReady), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory and FIFO models with transaction logs
  int          cyc = 0, lastAcc = 0, doneCyc = 0;
  int          nRd = 0, nWr = 0, nPush = 0, doneCnt = 0;
  logic [31:0] popCnt = '0;
  logic [63:0] rdLog   [256];
  logic [63:0] wrALog  [256];
  logic [63:0] wrDLog  [256];
  logic [1:0]  wrSLog  [256];
  logic [63:0] pushLog [256];

  assign memGnt      = memReq && gntOn;
  assign fifoPopData = {popCnt, ~popCnt};

  function automatic logic [63:0] pat(input logic [63:0] a);
    return {a[31:0] ^ 32'h5A5A_0F0F, a[31:0]};
  endfunction

  function automatic logic [63:0] keep(input logic [63:0] v, input int w);
    if (w == 3) return v;
    return v & ((64'd1 << (8 << w)) - 64'd1);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    memRspValid <= memReq && memGnt && !memWe;
    memRspData  <= pat(memAddr);
    if (memReq && memGnt) begin
      if (memWe) begin
        wrALog[nWr[7:0]] <= memAddr;
        wrDLog[nWr[7:0]] <= memWrData;
        wrSLog[nWr[7:0]] <= memSize;
        nWr <= nWr + 1;
        lastAcc <= cyc;
      end else begin
        rdLog[nRd[7:0]] <= memAddr;
        nRd <= nRd + 1;
      end
    end
    if (fifoPushValid && fifoPushReady) begin
      pushLog[nPush[7:0]] <= fifoPushData;
      nPush <= nPush + 1;
      lastAcc <= cyc;
    end
    if (fifoPop) popCnt <= popCnt + 32'd1;
    if (done) begin
      doneCnt <= doneCnt + 1;
      doneCyc <= cyc;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  task automatic waitDone(input int base);
    for (int i = 0; i < 3000 && doneCnt == base; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] modeWord(input logic dir, input logic [1:0] w, input logic inc);
    return {14'b0, 1'b0, dir, 10'b0, w, 3'b0, inc};
  endfunction

  task automatic runVec(input vec_t v);
    int n, rdI, wrI, puI, dnB;
    logic [31:0] popB;
    logic [63:0] step, al, a;
    string tagA;
    blkCount = v.cnt; blkSize = v.sz;
    wr(12'h410, modeWord(v.dir, v.wid, v.inc));
    wr(12'h440, v.addr[31:0]);
    wr(12'h444, v.addr[63:32]);
    rdI = nRd; wrI = nWr; puI = nPush; dnB = doneCnt; popB = popCnt;
    wr(12'h414, 32'h1);
    waitDone(dnB);
    repeat (3) @(negedge clk);
    n    = (int'(v.cnt) * int'(v.sz)) >> v.wid;
    step = v.inc ? (64'd1 << v.wid) : 64'd0;
    al   = v.addr & ~((64'd1 << v.wid) - 64'd1);
    tagA = (al != v.addr) ? "R7 aligned address" : "R6 beat address";
    // R8: one done, one cycle after final acceptance
    chk("R8 done count", 64'(doneCnt - dnB), 64'd1);
    chk("R8 done timing", 64'(doneCyc), 64'(lastAcc + 1));
    chk("R8 busy low", 64'(busy), 64'd0);
    if (!v.dir) begin
      chk("R3 read beats", 64'(nRd - rdI), 64'(n));
      chk("R3 push beats", 64'(nPush - puI), 64'(n));
      for (int i = 0; i < n; i++) begin
        a = al + 64'(i) * step;
        chk(tagA, rdLog[8'(rdI + i)], a);
        chk("R3 R5 pushed word", pushLog[8'(puI + i)], keep(pat(a), int'(v.wid)));
      end
    end else begin
      chk("R4 write beats", 64'(nWr - wrI), 64'(n));
      for (int i = 0; i < n; i++) begin
        a = al + 64'(i) * step;
        chk(tagA, wrALog[8'(wrI + i)], a);
        chk("R4 R5 written word", wrDLog[8'(wrI + i)],
            keep({popB + 32'(i), ~(popB + 32'(i))}, int'(v.wid)));
        chk("R5 size", 64'(wrSLog[8'(wrI + i)]), 64'(v.wid));
      end
    end
  endtask

  initial begin : wdog
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    int base, dnB;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R2 reset state, R10 reset value of channel bits
    chk("R2 busy after reset", 64'(busy), 64'd0);
    chk("R2 done after reset", 64'(done), 64'd0);
    chk("R2 memReq after reset", 64'(memReq), 64'd0);
    rd(12'h418, v); chk("R10 channel reset value", 64'(v), 64'h300);
    rd(12'h410, v); chk("R1 mode reset", 64'(v), 64'h0);

    // R1 register readback
    wr(12'h410, 32'hFFFF_FFFF);
    rd(12'h410, v); chk("R1 mode readback", 64'(v), 64'h0003_0031);
    wr(12'h440, 32'hDEAD_BEE8);
    wr(12'h444, 32'h1234_5678);
    rd(12'h440, v); chk("R1 addr low", 64'(v), 64'hDEAD_BEE8);
    rd(12'h444, v); chk("R1 addr high", 64'(v), 64'h1234_5678);
    rd(12'h420, v); chk("R1 unmapped", 64'(v), 64'h0);

    // main table
    for (int k = 0; k < NVEC; k++) runVec(VECS[k]);

    // R9 zero length
    blkCount = 16'd0; blkSize = 12'd16;
    wr(12'h410, modeWord(1'b0, 2'd3, 1'b1));
    base = nRd;
    wr(12'h414, 32'h1);
    chk("R9 done after zero-length start", 64'(done), 64'd1);
    chk("R9 busy stays low", 64'(busy), 64'd0);
    @(negedge clk);
    chk("R9 done is one cycle", 64'(done), 64'd0);
    chk("R9 no memory request", 64'(nRd - base), 64'd0);

    // R2 busy readback, R11 second start ignored, R12 stall hold
    gntOn = 1'b0;
    blkCount = 16'd1; blkSize = 12'd16;
    wr(12'h440, 32'h800);
    wr(12'h444, 32'h0);
    dnB = doneCnt; base = nRd;
    wr(12'h414, 32'h1);
    rd(12'h414, v); chk("R2 ctrl reads busy, start clear", 64'(v), 64'h2);
    wr(12'h414, 32'h1);
    repeat (3) @(negedge clk);
    chk("R12 request held during stall", 64'(memReq), 64'd1);
    chk("R12 address held during stall", memAddr, 64'h800);
    gntOn = 1'b1;
    waitDone(dnB);
    repeat (20) @(negedge clk);
    chk("R11 beat count unchanged", 64'(nRd - base), 64'd2);
    chk("R11 single done", 64'(doneCnt - dnB), 64'd1);

    // R10 abort during stalled push
    fifoPushReady = 1'b0;
    blkCount = 16'd4; blkSize = 12'd8;
    dnB = doneCnt;
    wr(12'h414, 32'h1);
    repeat (5) @(negedge clk);
    chk("R10 stalled before abort", 64'(busy), 64'd1);
    wr(12'h418, 32'h200);
    @(negedge clk);
    chk("R10 busy cleared by reset", 64'(busy), 64'd0);
    chk("R10 push dropped", 64'(fifoPushValid), 64'd0);
    fifoPushReady = 1'b1;
    repeat (10) @(negedge clk);
    chk("R10 no done after abort", 64'(doneCnt - dnB), 64'd0);
    base = nRd;
    wr(12'h414, 32'h1);
    chk("R10 start ignored in reset", 64'(busy), 64'd0);
    repeat (3) @(negedge clk);
    chk("R10 no request in reset", 64'(nRd - base), 64'd0);
    wr(12'h418, 32'h300);
    rd(12'h418, v); chk("R10 released readback", 64'(v), 64'h300);
    runVec(VECS[0]);

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule